// File: doc/BRIEF.md
# Per-line input glitch and debounce conditioner

This block conditions a bank of general-purpose input lines before their levels reach software readback and input-change detection. Each pin first passes through a two-flop synchronizer. The synchronized level goes straight to the peripheral path. Per line, the readback path can take the synchronized level as it is or can take it through a filter. The filter has two modes. In the fast mode it rejects short glitches using the system clock. In the slow mode it acts as a debouncer that samples on a strobe from a programmable prescaler.

Configuration uses write-one-to-set and write-one-to-clear operations on two status words, one for filter enable and one for clock source, and a direct write of the prescaler divide value. Only the readback word and the per-line change pulses ever see filtered data.

Top module: `pin_input_conditioner`

## Requirements
- R1: A write with `cfg_op`=1 sets every bit of `fen_o` whose `cfg_wdata` bit is 1 and leaves the other bits unchanged.
- R2: A write with `cfg_op`=2 clears every bit of `fen_o` whose `cfg_wdata` bit is 1 and leaves the other bits unchanged. Op codes 3 and 4 do the same set and clear on `src_o`. Op code 0 and codes 6 and 7 change nothing.
- R3: Bit i of `src_o` selects the mode for line i: 0 selects the system-clock glitch filter and 1 selects the slow debouncer. The status words update on the clock edge that takes the write.
- R4: `periph_o` equals the pin level delayed by two clock edges and never depends on `fen_o`, `src_o` or the divider.
- R5: With the filter off for a line, `pdsr_o` follows the pin with the same two-edge delay.
- R6: In glitch mode the filtered level takes a new value only after the synchronized level has held it on two successive clock edges. A one-cycle pulse never reaches `pdsr_o`, a two-cycle pulse does, and a held change appears four edges after the pin moves.
- R7: In debounce mode the line samples only on prescaler strobes. A new level is accepted only when two successive strobe samples agree, so a pulse shorter than a strobe period is rejected.
- R8: Clearing a line's filter enable makes `pdsr_o` equal the synchronized pin from the cycle after the write.
- R9: `change_o[i]` is high for exactly the cycles in which `pdsr_o[i]` differs from its value on the previous cycle.
- R10: After reset, `fen_o` and `src_o` are zero, `div_o` holds the reset divide value (3 by default), and the data outputs are zero.
- R11: A write with `cfg_op`=5 loads `div_o` from `cfg_wdata`. The prescaler strobes once every `div_o`+1 cycles, and a new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NLINES | Asynchronous pin levels |
| cfg_op | input | 3 | Configuration operation code (0 means no operation) |
| cfg_wdata | input | WD | Write data: a line mask, or the divide value |
| fen_o | output | NLINES | Filter enable status |
| src_o | output | NLINES | Filter clock source status |
| div_o | output | DIV_W | Prescaler divide value |
| periph_o | output | NLINES | Synchronized, unfiltered levels for peripherals |
| pdsr_o | output | NLINES | Readback levels, filtered where enabled |
| change_o | output | NLINES | Per-line readback change pulses |

## Verification
The hardest state to reach is a debouncer that still holds a stale level while the pin has already settled elsewhere. Disabling the filter at that moment is the only way to show that readback jumps straight to the synchronized pin. The bench sets a long divide value so that the debouncer lags, moves the pin, and confirms that readback has not followed. It then clears the enable and checks the next cycle. Pulses one cycle or one strobe period shorter than the acceptance threshold are driven directly. A long random phase then mixes pin toggles with configuration writes at arbitrary strobe phases against a cycle model.

// File: rtl/gfilt_pkg.sv
package gfilt_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_FEN_SET = 3'd1,
        OP_FEN_CLR = 3'd2,
        OP_SRC_SET = 3'd3,
        OP_SRC_CLR = 3'd4,
        OP_DIV_WR  = 3'd5
    } cfg_op_e;

    typedef struct packed {
        logic en;
        logic slow;
    } line_cfg_t;

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gfilt_sync2.sv
module gfilt_sync2 #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/gfilt_prescale.sv
module gfilt_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= div_i;
        else             cnt_q <= cnt_q - DIV_W'(1);
    end

    // R11
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/gfilt_cfg.sv
module gfilt_cfg #(
    parameter int          N       = 8,
    parameter int          DIV_W   = 8,
    parameter int          WD      = 8,
    parameter int unsigned DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [WD-1:0]    wdata_i,
    output logic [N-1:0]     fen_o,
    output logic [N-1:0]     src_o,
    output logic [DIV_W-1:0] div_o
);
    import gfilt_pkg::*;

    cfg_op_e      op;
    logic [N-1:0] mask;

    assign op   = cfg_op_e'(op_i);
    assign mask = wdata_i[N-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fen_o <= '0;
            src_o <= '0;
            div_o <= DIV_W'(DIV_RST);
        end else begin
            case (op)
                OP_FEN_SET: fen_o <= fen_o | mask;
                OP_FEN_CLR: fen_o <= fen_o & ~mask;
                OP_SRC_SET: src_o <= src_o | mask;
                OP_SRC_CLR: src_o <= src_o & ~mask;
                OP_DIV_WR:  div_o <= wdata_i[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // R1
    fen_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1) |=> (((fen_o & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])) &&
                            ((fen_o & ~$past(wdata_i[N-1:0])) == ($past(fen_o) & ~$past(wdata_i[N-1:0])))));
    // R2
    fen_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2) |=> (((fen_o & $past(wdata_i[N-1:0])) == '0) &&
                            ((fen_o & ~$past(wdata_i[N-1:0])) == ($past(fen_o) & ~$past(wdata_i[N-1:0])))));
endmodule

// File: rtl/gfilt_line.sv
module gfilt_line (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_i,
    input  gfilt_pkg::line_cfg_t cfg_i,
    input  logic                 tick_i,
    output logic                 out_o
);
    logic smp_q;
    logic take;

    assign take = cfg_i.slow ? tick_i : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= 1'b0;
            smp_q <= 1'b0;
        end else if (!cfg_i.en) begin
            out_o <= s_i;
            smp_q <= s_i;
        end else if (take) begin
            smp_q <= s_i;
            if (s_i == smp_q) out_o <= s_i;
        end
    end

    // R6
    filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.en && $past(cfg_i.en) && out_o != $past(out_o)) |-> ($past(s_i) == out_o));
endmodule

// File: rtl/pin_input_conditioner.sv
module pin_input_conditioner #(
    parameter int          NLINES  = 8,
    parameter int          DIV_W   = 8,
    parameter int unsigned DIV_RST = 3,
    parameter int          WD      = gfilt_pkg::wmax(NLINES, DIV_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] pin_i,
    input  logic [2:0]        cfg_op,
    input  logic [WD-1:0]     cfg_wdata,
    output logic [NLINES-1:0] fen_o,
    output logic [NLINES-1:0] src_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [NLINES-1:0] periph_o,
    output logic [NLINES-1:0] pdsr_o,
    output logic [NLINES-1:0] change_o
);
    import gfilt_pkg::*;

    logic [NLINES-1:0] sync_lv;
    logic [NLINES-1:0] filt_lv;
    logic [NLINES-1:0] pdsr_q;
    logic              tick;

    gfilt_sync2 #(.N(NLINES)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(sync_lv)
    );

    gfilt_cfg #(.N(NLINES), .DIV_W(DIV_W), .WD(WD), .DIV_RST(DIV_RST)) u_cfg (
        .clk(clk), .rst(rst), .op_i(cfg_op), .wdata_i(cfg_wdata),
        .fen_o(fen_o), .src_o(src_o), .div_o(div_o)
    );

    gfilt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .div_i(div_o), .tick_o(tick)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_cfg_t lcfg;
        assign lcfg.en   = fen_o[i];
        assign lcfg.slow = src_o[i];
        gfilt_line u_line (
            .clk(clk), .rst(rst), .s_i(sync_lv[i]), .cfg_i(lcfg),
            .tick_i(tick), .out_o(filt_lv[i])
        );
    end

    assign periph_o = sync_lv;
    assign pdsr_o   = (fen_o & filt_lv) | (~fen_o & sync_lv);

    always_ff @(posedge clk) begin
        if (rst) pdsr_q <= '0;
        else     pdsr_q <= pdsr_o;
    end

    assign change_o = pdsr_o ^ pdsr_q;

    // R9
    change_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (change_o == (pdsr_o ^ $past(pdsr_o))));
    // R4
    periph_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> (periph_o == $past(pin_i, 2)));
endmodule

// File: tb/pin_input_conditioner_tb_top.sv
`timescale 1ns/1ps
module pin_input_conditioner_tb_top;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int WD = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pin = '0;
    logic [2:0]    op  = 3'd0;
    logic [WD-1:0] wdata = '0;
    logic [N-1:0]  fen_o, src_o, periph_o, pdsr_o, change_o;
    logic [DW-1:0] div_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_input_conditioner #(.NLINES(N), .DIV_W(DW), .DIV_RST(3)) dut_i (
        .clk(clk), .rst(rst), .pin_i(pin), .cfg_op(op), .cfg_wdata(wdata),
        .fen_o(fen_o), .src_o(src_o), .div_o(div_o), .periph_o(periph_o),
        .pdsr_o(pdsr_o), .change_o(change_o)
    );

    // cycle model built from the requirements
    logic [N-1:0]  m_a, m_s, m_out, m_smp, m_fen, m_src, m_pq;
    logic [DW-1:0] m_div, m_cnt;

    function automatic logic [N-1:0] exp_rb(input logic [N-1:0] en, input logic [N-1:0] f,
                                            input logic [N-1:0] s);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = en[i] ? f[i] : s[i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_a <= '0; m_s <= '0; m_out <= '0; m_smp <= '0;
            m_fen <= '0; m_src <= '0; m_pq <= '0; m_div <= 8'd3; m_cnt <= '0;
        end else begin
            m_a <= pin;
            m_s <= m_a;
            m_pq <= exp_rb(m_fen, m_out, m_s);
            m_cnt <= (m_cnt == 0) ? m_div : m_cnt - 8'd1;
            for (int i = 0; i < N; i++) begin
                if (!m_fen[i]) begin
                    m_out[i] <= m_s[i];
                    m_smp[i] <= m_s[i];
                end else if (!m_src[i] || m_cnt == 0) begin
                    m_smp[i] <= m_s[i];
                    if (m_s[i] == m_smp[i]) m_out[i] <= m_s[i];
                end
            end
            case (op)
                3'd1: m_fen <= m_fen | wdata;
                3'd2: m_fen <= m_fen & ~wdata;
                3'd3: m_src <= m_src | wdata;
                3'd4: m_src <= m_src & ~wdata;
                3'd5: m_div <= wdata;
                default: ;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !done) begin
            chk("R4 model periph", periph_o, m_s);
            chk("R5 R6 R7 model pdsr", pdsr_o, exp_rb(m_fen, m_out, m_s));
            chk("R9 model change", change_o, exp_rb(m_fen, m_out, m_s) ^ m_pq);
            chk("R1 R2 model fen", fen_o, m_fen);
            chk("R3 model src", src_o, m_src);
            chk("R11 model div", div_o, m_div);
        end
    end

    task automatic wr(input logic [2:0] o, input logic [WD-1:0] d);
        @(negedge clk); op = o; wdata = d;
        @(negedge clk); op = 3'd0; wdata = '0;
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        bit seen;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_on = 1'b1;
        // R10 reset state
        chk("R10 fen", fen_o, 0);
        chk("R10 src", src_o, 0);
        chk("R10 div", div_o, 3);
        chk("R10 pdsr", pdsr_o, 0);
        chk("R10 change", change_o, 0);
        // R1 / R2 / R3 / R11
        wr(3'd1, 8'h05); chk("R1 set", fen_o, 8'h05);
        wr(3'd1, 8'h30); chk("R1 set keep", fen_o, 8'h35);
        wr(3'd2, 8'h11); chk("R2 clear", fen_o, 8'h24);
        wr(3'd6, 8'hFF); chk("R2 unused op", fen_o, 8'h24);
        wr(3'd3, 8'hC3); chk("R3 src set", src_o, 8'hC3);
        wr(3'd4, 8'h42); chk("R3 src clear", src_o, 8'h81);
        wr(3'd5, 8'd9);  chk("R11 div", div_o, 9);
        wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'd3);
        // R5 unfiltered latency, R4, R9
        waitc(4);
        pin[0] = 1'b1;
        waitc(1); chk("R5 early", pdsr_o[0], 0);
        waitc(1); chk("R5 rise", pdsr_o[0], 1);
        chk("R4 periph rise", periph_o[0], 1);
        chk("R9 pulse", change_o[0], 1);
        waitc(1); chk("R9 one cycle", change_o[0], 0);
        // R6 glitch filter
        wr(3'd1, 8'h01);
        pin[0] = 1'b0; waitc(8);
        pin[0] = 1'b1;
        waitc(2); chk("R4 periph with filter", periph_o[0], 1);
        waitc(1); chk("R6 not yet", pdsr_o[0], 0);
        waitc(1); chk("R6 latency", pdsr_o[0], 1);
        waitc(4);
        pin[0] = 1'b0; waitc(1); pin[0] = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin waitc(1); if (pdsr_o[0] == 1'b0) seen = 1'b1; end
        chk("R6 one-cycle pulse rejected", seen, 0);
        pin[0] = 1'b0; waitc(2); pin[0] = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin waitc(1); if (pdsr_o[0] == 1'b0) seen = 1'b1; end
        chk("R6 two-cycle pulse passed", seen, 1);
        // R7 debounce, divide 3 -> strobe period 4
        wr(3'd3, 8'h01);
        pin[0] = 1'b0; waitc(20); chk("R7 settle low", pdsr_o[0], 0);
        pin[0] = 1'b1; waitc(14); chk("R7 accept high", pdsr_o[0], 1);
        pin[0] = 1'b0; waitc(2); pin[0] = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 14; i++) begin waitc(1); if (pdsr_o[0] == 1'b0) seen = 1'b1; end
        chk("R7 short pulse rejected", seen, 0);
        // R8 disable with a lagging debouncer
        wr(3'd5, 8'd40);
        pin[0] = 1'b0; waitc(100); chk("R8 settled low", pdsr_o[0], 0);
        pin[0] = 1'b1; waitc(5); chk("R8 still filtered", pdsr_o[0], 0);
        wr(3'd2, 8'h01); chk("R8 tracks after disable", pdsr_o[0], 1);
        // random phase
        wr(3'd5, 8'd2);
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            pin = pin ^ N'($urandom & $urandom & $urandom);
            if ($urandom_range(0, 29) == 0) begin
                op = 3'($urandom_range(1, 5));
                wdata = (op == 3'd5) ? 8'($urandom_range(0, 6)) : 8'($urandom);
            end else begin
                op = 3'd0; wdata = '0;
            end
        end
        @(negedge clk); op = 3'd0;
        waitc(2);
        summary();
    end
endmodule